// File: doc/BRIEF.md
# Oscillator Tuning Loop Controller

This block produces the two tuning codes of a digitally controlled oscillator: a coarse code and a fine code. In open-loop operation software writes both codes and the block passes them to the oscillator unchanged. In closed-loop operation the block receives, once per reference-clock period, the number of oscillator cycles counted in that period. It compares that number with a target of `mul_int + mul_frac/65536` cycles and corrects the codes toward the target. The coarse code is searched first. The fine code is trimmed only after coarse lock has been declared.

The coarse search starts from whatever coarse value software wrote before entering closed loop. Every correction is proportional to the count error and is capped by a separate programmable maximum step for each code. A read handshake captures both codes into read registers and raises a ready flag. The oscillator itself and any clock-domain crossing are outside the block; the cycle count arrives as a plain input with a valid strobe.

Top module: `dco_loop_tuner`

## Requirements
- R1: While `mode`=0, a `code_wr` pulse loads `coarse_wdata` and `fine_wdata` into `coarse_code` and `fine_code` at the next clock edge, whatever the state of `en`.
- R2: While `mode`=0 and `code_wr`=0, both codes hold their values, and `meas_valid` pulses have no effect on them.
- R3: On each accepted measurement a 16-bit fraction accumulator adds `mul_frac`. The target for that period is `mul_int` plus the carry out of that addition, and the error is the target minus `meas_count`. The accumulator is cleared whenever closed loop is not active, so a first measurement sees carry 0 unless the fraction overflows.
- R4: Closed loop is active when `en`=1 and `mode`=1. The coarse search begins at the coarse value already held. A positive error raises the code and a negative error lowers it. The fine code is untouched during the search.
- R5: Before coarse lock, each measurement with a nonzero error moves `coarse_code` by min(|error|, `coarse_max_step`). The result saturates at 0 and at all ones.
- R6: `coarse_lock` rises on a measurement whose error is zero, or whose sign differs from that of the previous measurement. That measurement does not move the coarse code, and after it the coarse code stays fixed while closed loop remains active.
- R7: After coarse lock, a measurement with |error| ≤ 1 sets `fine_lock` and leaves `fine_code` alone. Any larger error clears `fine_lock` and moves `fine_code` by min(|error|, `fine_max_step`) toward the target, saturating at 0 and all ones. `fine_lock` implies `coarse_lock`.
- R8: While closed loop is active, `code_wr` has no effect on either code.
- R9: Whenever closed loop is not active, both lock flags are cleared. Re-entering closed loop starts a new coarse search.
- R10: `ready` is 0 after reset and whenever `en`=0. A `sync_req` while `en`=1 copies the current codes into `rd_coarse`/`rd_fine` and drops `ready` for one cycle. `ready` is then raised on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable |
| mode | input | 1 | 0 open loop, 1 closed loop |
| code_wr | input | 1 | Write strobe for the code values |
| coarse_wdata | input | CW | Coarse code to write |
| fine_wdata | input | FW | Fine code to write |
| coarse_max_step | input | CW | Largest coarse change per measurement |
| fine_max_step | input | FW | Largest fine change per measurement |
| mul_int | input | CNTW | Integer part of the target multiplier |
| mul_frac | input | FRW | Fractional part of the multiplier, in units of 2^-FRW |
| sync_req | input | 1 | Request to capture codes for reading |
| meas_valid | input | 1 | A reference period has ended |
| meas_count | input | CNTW | Oscillator cycles counted in that period |
| coarse_code | output | CW | Coarse code to the oscillator |
| fine_code | output | FW | Fine code to the oscillator |
| ready | output | 1 | Captured read values are valid |
| rd_coarse | output | CW | Captured coarse code |
| rd_fine | output | FW | Captured fine code |
| coarse_lock | output | 1 | Coarse search finished |
| fine_lock | output | 1 | Fine error within one count |

## Verification
Open-loop writes are swept over every coarse and fine pair. For the coarse phase, single measurements are swept over every coarse step limit, three start codes and errors from −20 to +20. This separates the proportional region, the capped region and both saturation ends. The same sweep is repeated for the fine code after a forced lock. Closed loops are then run against a linear oscillator model for several integer and fractional multipliers, and each period is compared with an arithmetic reference. This exposes wrong carry timing, wrong sign-flip detection and a lock band that is off by one. Dedicated sequences cover the immediate lock on zero error, writes ignored during closed loop, and lock clearing on exit.

// File: rtl/dco_loop_tuner.sv
module dco_loop_tuner #(
  parameter int CW   = 4,
  parameter int FW   = 4,
  parameter int CNTW = 8,
  parameter int FRW  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            mode,
  input  logic            code_wr,
  input  logic [CW-1:0]   coarse_wdata,
  input  logic [FW-1:0]   fine_wdata,
  input  logic [CW-1:0]   coarse_max_step,
  input  logic [FW-1:0]   fine_max_step,
  input  logic [CNTW-1:0] mul_int,
  input  logic [FRW-1:0]  mul_frac,
  input  logic            sync_req,
  input  logic            meas_valid,
  input  logic [CNTW-1:0] meas_count,
  output logic [CW-1:0]   coarse_code,
  output logic [FW-1:0]   fine_code,
  output logic            ready,
  output logic [CW-1:0]   rd_coarse,
  output logic [FW-1:0]   rd_fine,
  output logic            coarse_lock,
  output logic            fine_lock
);
  localparam int EW = CNTW + 2;
  localparam int SW = (EW > CW) ? ((EW > FW) ? EW : FW) : ((CW > FW) ? CW : FW);

  logic [CW-1:0]  coarse_q;
  logic [FW-1:0]  fine_q;
  logic [FRW-1:0] frac_acc;
  logic           have_prev, prev_neg, sync_pend;

  wire            active = en && mode;
  wire [FRW:0]    frac_sum = {1'b0, frac_acc} + {1'b0, mul_frac};
  wire [EW-1:0]   target = {2'b00, mul_int} + {{(EW-1){1'b0}}, frac_sum[FRW]};
  wire [EW-1:0]   err = target - {2'b00, meas_count};
  wire            err_neg = err[EW-1];
  wire            err_zero = (err == '0);
  wire [EW-1:0]   mag = err_neg ? (~err + 1'b1) : err;
  wire            in_band = (mag <= EW'(1));

  wire [CW-1:0]   c_step = (SW'(mag) > SW'(coarse_max_step)) ? coarse_max_step : mag[CW-1:0];
  wire [FW-1:0]   f_step = (SW'(mag) > SW'(fine_max_step)) ? fine_max_step : mag[FW-1:0];

  wire [CW:0]     c_sum = {1'b0, coarse_q} + {1'b0, c_step};
  wire [FW:0]     f_sum = {1'b0, fine_q} + {1'b0, f_step};
  wire [CW-1:0]   c_up = c_sum[CW] ? '1 : c_sum[CW-1:0];
  wire [FW-1:0]   f_up = f_sum[FW] ? '1 : f_sum[FW-1:0];
  wire [CW-1:0]   c_dn = (c_step > coarse_q) ? '0 : coarse_q - c_step;
  wire [FW-1:0]   f_dn = (f_step > fine_q) ? '0 : fine_q - f_step;
  wire            sign_flip = have_prev && (prev_neg != err_neg);

  assign coarse_code = coarse_q;
  assign fine_code   = fine_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coarse_q    <= '0;
      fine_q      <= '0;
      frac_acc    <= '0;
      have_prev   <= 1'b0;
      prev_neg    <= 1'b0;
      coarse_lock <= 1'b0;
      fine_lock   <= 1'b0;
    end else if (!active) begin
      frac_acc    <= '0;
      have_prev   <= 1'b0;
      coarse_lock <= 1'b0;
      fine_lock   <= 1'b0;
      if (code_wr && !mode) begin
        coarse_q <= coarse_wdata;
        fine_q   <= fine_wdata;
      end
    end else if (meas_valid) begin
      frac_acc <= frac_sum[FRW-1:0];
      if (!coarse_lock) begin
        have_prev <= 1'b1;
        prev_neg  <= err_neg;
        if (err_zero || sign_flip)
          coarse_lock <= 1'b1;
        else
          coarse_q <= err_neg ? c_dn : c_up;
      end else if (in_band) begin
        fine_lock <= 1'b1;
      end else begin
        fine_lock <= 1'b0;
        fine_q    <= err_neg ? f_dn : f_up;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready     <= 1'b0;
      sync_pend <= 1'b0;
      rd_coarse <= '0;
      rd_fine   <= '0;
    end else if (!en) begin
      ready     <= 1'b0;
      sync_pend <= 1'b0;
    end else if (sync_req) begin
      ready     <= 1'b0;
      sync_pend <= 1'b1;
      rd_coarse <= coarse_q;
      rd_fine   <= fine_q;
    end else if (sync_pend) begin
      ready     <= 1'b1;
      sync_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/dco_loop_tuner_chk.sv
module dco_loop_tuner_chk #(
  parameter int CW = 4,
  parameter int FW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          mode,
  input logic          code_wr,
  input logic          meas_valid,
  input logic [CW-1:0] coarse_wdata,
  input logic [FW-1:0] fine_wdata,
  input logic [CW-1:0] coarse_max_step,
  input logic [FW-1:0] fine_max_step,
  input logic [CW-1:0] coarse_code,
  input logic [FW-1:0] fine_code,
  input logic          ready,
  input logic          coarse_lock,
  input logic          fine_lock
);
  a_r1_open_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && code_wr) |=> (coarse_code == $past(coarse_wdata)) && (fine_code == $past(fine_wdata)));

  a_r2_open_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && !code_wr) |=> $stable(coarse_code) && $stable(fine_code));

  a_r5_coarse_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode) |=> (((coarse_code >= $past(coarse_code)) ? (coarse_code - $past(coarse_code))
                       : ($past(coarse_code) - coarse_code)) <= $past(coarse_max_step)));

  a_r7_fine_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode) |=> (((fine_code >= $past(fine_code)) ? (fine_code - $past(fine_code))
                       : ($past(fine_code) - fine_code)) <= $past(fine_max_step)));

  a_r6_coarse_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode && coarse_lock) |=> $stable(coarse_code));

  a_r7_fine_after_coarse: assert property (@(posedge clk) disable iff (!rst_n)
    fine_lock |-> coarse_lock);

  a_r8_closed_no_meas_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode && !meas_valid) |=> $stable(coarse_code) && $stable(fine_code));

  a_r9_exit_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && mode) |=> !coarse_lock && !fine_lock);

  a_r10_ready_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !ready);
endmodule

bind dco_loop_tuner dco_loop_tuner_chk #(.CW(CW), .FW(FW)) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .code_wr(code_wr),
  .meas_valid(meas_valid), .coarse_wdata(coarse_wdata), .fine_wdata(fine_wdata),
  .coarse_max_step(coarse_max_step), .fine_max_step(fine_max_step),
  .coarse_code(coarse_code), .fine_code(fine_code), .ready(ready),
  .coarse_lock(coarse_lock), .fine_lock(fine_lock)
);

// File: tb/dco_loop_tuner_tb_top.sv
module dco_loop_tuner_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 0, mode = 0, code_wr = 0, sync_req = 0, meas_valid = 0;
  logic [3:0] coarse_wdata = 0, fine_wdata = 0, coarse_max_step = 0, fine_max_step = 0;
  logic [7:0] mul_int = 0, meas_count = 0;
  logic [15:0] mul_frac = 0;
  logic [3:0] coarse_code, fine_code, rd_coarse, rd_fine;
  logic ready, coarse_lock, fine_lock;

  int checks = 0, fails = 0;
  bit done = 0;
  int mc, mf, macc;
  bit mclk, mflk, mhave, mprev;

  always #10 clk = ~clk;

  dco_loop_tuner dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .code_wr(code_wr),
    .coarse_wdata(coarse_wdata), .fine_wdata(fine_wdata),
    .coarse_max_step(coarse_max_step), .fine_max_step(fine_max_step),
    .mul_int(mul_int), .mul_frac(mul_frac), .sync_req(sync_req),
    .meas_valid(meas_valid), .meas_count(meas_count),
    .coarse_code(coarse_code), .fine_code(fine_code), .ready(ready),
    .rd_coarse(rd_coarse), .rd_fine(rd_fine),
    .coarse_lock(coarse_lock), .fine_lock(fine_lock)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic open_write(input int c, input int f);
    @(negedge clk);
    mode = 0; code_wr = 1; coarse_wdata = c[3:0]; fine_wdata = f[3:0];
    @(negedge clk);
    code_wr = 0;
    mc = c; mf = f;
  endtask

  task automatic enter_closed();
    @(negedge clk);
    mode = 1;
    mclk = 0; mflk = 0; macc = 0; mhave = 0; mprev = 0;
  endtask

  task automatic m_step(input int cnt);
    int sum, tgt, err, mag, st;
    bit neg;
    sum = macc + int'(mul_frac);
    tgt = int'(mul_int) + (sum >> 16);
    macc = sum & 'hFFFF;
    err = tgt - cnt;
    neg = err < 0;
    mag = neg ? -err : err;
    if (!mclk) begin
      if (err == 0 || (mhave && neg != mprev)) mclk = 1;
      else begin
        st = (mag < int'(coarse_max_step)) ? mag : int'(coarse_max_step);
        mc = neg ? ((mc - st < 0) ? 0 : mc - st) : ((mc + st > 15) ? 15 : mc + st);
      end
      mhave = 1; mprev = neg;
    end else if (mag <= 1) begin
      mflk = 1;
    end else begin
      mflk = 0;
      st = (mag < int'(fine_max_step)) ? mag : int'(fine_max_step);
      mf = neg ? ((mf - st < 0) ? 0 : mf - st) : ((mf + st > 15) ? 15 : mf + st);
    end
  endtask

  task automatic meas(input int cnt);
    @(negedge clk);
    meas_valid = 1; meas_count = cnt[7:0];
    @(negedge clk);
    meas_valid = 0;
    m_step(cnt);
  endtask

  task automatic cmp_all(input string req);
    chk({req, " coarse"}, coarse_code, mc);
    chk({req, " fine"}, fine_code, mf);
    chk({req, " coarse_lock"}, coarse_lock, mclk);
    chk({req, " fine_lock"}, fine_lock, mflk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int starts[3];
    starts[0] = 0; starts[1] = 7; starts[2] = 15;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    chk("R1 reset coarse", coarse_code, 0);
    chk("R1 reset fine", fine_code, 0);
    chk("R10 reset ready", ready, 0);
    chk("R9 reset locks", coarse_lock | fine_lock, 0);

    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++) begin
        en = (c[0] == 1'b1);
        open_write(c, f);
        chk("R1 open coarse", coarse_code, c);
        chk("R1 open fine", fine_code, f);
      end

    en = 1;
    open_write(9, 3);
    for (int k = 0; k < 8; k++) meas(k * 30);
    chk("R2 hold coarse", coarse_code, 9);
    chk("R2 hold fine", fine_code, 3);

    en = 0;
    @(negedge clk); sync_req = 1;
    @(negedge clk); sync_req = 0;
    @(negedge clk);
    chk("R10 ready while disabled", ready, 0);
    en = 1;
    @(negedge clk); sync_req = 1;
    @(negedge clk); sync_req = 0;
    chk("R10 ready low after sync", ready, 0);
    @(negedge clk);
    chk("R10 ready high", ready, 1);
    chk("R10 rd_coarse", rd_coarse, 9);
    chk("R10 rd_fine", rd_fine, 3);
    open_write(2, 6);
    chk("R10 rd holds until sync", rd_coarse, 9);
    en = 0;
    @(negedge clk);
    chk("R10 ready cleared on disable", ready, 0);
    en = 1;

    mul_int = 100; mul_frac = 0; fine_max_step = 3;
    for (int cs = 1; cs < 16; cs++)
      for (int si = 0; si < 3; si++)
        for (int cnt = 80; cnt <= 120; cnt += 5) begin
          coarse_max_step = cs[3:0];
          open_write(starts[si], 5);
          enter_closed();
          meas(cnt);
          chk("R5 coarse step", coarse_code, mc);
          chk("R4 fine untouched", fine_code, 5);
          chk("R6 zero-error lock", coarse_lock, mclk);
        end

    coarse_max_step = 15;
    open_write(7, 5);
    enter_closed();
    meas(97);
    chk("R4 coarse up on positive error", coarse_code, 10);
    meas(102);
    chk("R6 sign flip lock", coarse_lock, 1);
    chk("R6 no move on flip", coarse_code, 10);
    meas(90);
    chk("R6 coarse frozen after lock", coarse_code, 10);
    cmp_all("R7 first fine step");

    @(negedge clk);
    code_wr = 1; coarse_wdata = 1; fine_wdata = 1;
    @(negedge clk);
    code_wr = 0;
    chk("R8 closed write coarse", coarse_code, mc);
    chk("R8 closed write fine", fine_code, mf);

    @(negedge clk); mode = 0;
    @(negedge clk);
    chk("R9 exit clears coarse_lock", coarse_lock, 0);
    chk("R9 exit clears fine_lock", fine_lock, 0);
    enter_closed();
    meas(97);
    chk("R9 new search moves coarse", coarse_code, 13);

    mul_int = 100; mul_frac = 0;
    for (int fs = 1; fs < 16; fs++)
      for (int si = 0; si < 3; si++)
        for (int cnt = 80; cnt <= 120; cnt += 5) begin
          fine_max_step = fs[3:0];
          open_write(4, starts[si]);
          enter_closed();
          meas(100);
          meas(cnt);
          cmp_all("R7 fine step");
        end
    fine_max_step = 2;
    for (int d = -2; d <= 2; d++) begin
      open_write(4, 8);
      enter_closed();
      meas(100);
      meas(100 + d);
      cmp_all("R7 lock band");
    end

    mul_int = 50; mul_frac = 16'h8000; fine_max_step = 4;
    open_write(4, 8);
    enter_closed();
    meas(50);
    cmp_all("R3 first carry zero");
    meas(50);
    cmp_all("R3 carry gives target 51");
    meas(52);
    cmp_all("R3 carry back to zero");
    chk("R3 fine moved by 2", fine_code, 6);

    coarse_max_step = 8; fine_max_step = 2;
    for (int ii = 0; ii < 3; ii++)
      for (int fi = 0; fi < 4; fi++) begin
        mul_int = (ii == 0) ? 30 : (ii == 1) ? 47 : 62;
        mul_frac = 16'(fi * 16'h4000);
        open_write(0, 8);
        enter_closed();
        for (int p = 0; p < 40; p++) begin
          meas(4 * int'(coarse_code) + int'(fine_code) + 10);
          cmp_all("R3 R4 R7 loop");
        end
        if (ii == 1 && fi == 1) chk("R7 converges to fine lock", fine_lock, 1);
      end

    finish_run();
  end
endmodule